// File: doc/BRIEF.md
# Configurable 2x/4x I/O Gearbox

This block is a shared serializer and deserializer that serves a group of four pad lanes. It runs on one fast clock. On the receive side it gathers a serial bit stream from a pad into a parallel word for the fabric, one word every 2 or 4 fast clocks. On the transmit side it takes a parallel fabric word and sends it out bit by bit on a pad at the same rate. Both directions run at the same time. They share one framing counter and one ratio setting.

The ratio input picks between two uses of the four parallel nodes in each direction. In the 2x setting, two lanes of the group are served. Lane 0 and lane 2 each own a pair of nodes. In the 4x setting, only lane 0 is served and it owns all four nodes. Lanes that are not served connect pad and fabric directly through a bypass path. The ratio is captured once, in the first clock after reset is released. That clock is a configuration cycle with no shifting. After it, the block raises a transmit-take pulse at the start of each word period and a receive-valid strobe when each received word is complete.

Top module: `io_gearbox`

## Requirements
- R1: In 4x mode, the four bits received on pad_in[0] over one word period appear on rx_word[3] down to rx_word[0] in arrival order: the earliest bit is on rx_word[3] and the latest is on rx_word[0].
- R2: In 4x mode, the word on tx_word is sampled at the clock edge where tx_take is high. Then pad_out[0] shows tx_word[3], tx_word[2], tx_word[1] and tx_word[0], one bit per clock, starting right after that edge.
- R3: In 2x mode, the two bits received on pad_in[0] appear on rx_word[3:2] and the two bits received on pad_in[2] appear on rx_word[1:0]. In each pair, the earlier bit is on the higher index.
- R4: rx_vld is high for exactly one clock per completed word. The first high clock follows the 2nd (2x) or 4th (4x) operating edge after the configuration cycle. The word is held on rx_word between strobes.
- R5: tx_take is high on the first operating cycle and then once every 2 (2x) or 4 (4x) clocks.
- R6: In 2x mode, pad_out[0] sends tx_word[1] and then tx_word[0]. At the same time, pad_out[2] sends tx_word[3] and then tx_word[2].
- R7: A lane that is not served has rx_byp equal to its pad_in and pad_out equal to its tx_byp, with no delay. A served lane has rx_byp held at 0. The served lanes are 0 and 2 in 2x mode (ratio_i=0) and lane 0 alone in 4x mode (ratio_i=1).
- R8: ratio_i is sampled only on the first clock after reset is released. Later changes to ratio_i have no effect until the next reset.
- R9: While reset is asserted, rx_word, rx_vld and tx_take are 0, and every served lane drives pad_out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 1 | Ratio select: 0 for 2x, 1 for 4x (captured after reset) |
| pad_in | input | 4 | Serial data from the four pads |
| pad_out | output | 4 | Serial data to the four pads |
| rx_word | output | 4 | Deserialized parallel word to the fabric |
| rx_vld | output | 1 | One-clock strobe when a new rx_word is complete |
| rx_byp | output | 4 | Pad data passed through for lanes that are not served |
| tx_word | input | 4 | Parallel word from the fabric for serializing |
| tx_take | output | 1 | High on the clock edge where tx_word is sampled |
| tx_byp | input | 4 | Fabric data driven to pads of lanes that are not served |

## Verification
The hardest case to reach is a ratio change arriving after the configuration cycle while both directions are streaming. Only the unchanged framing and bit order at the ports show that the change was ignored. The stimulus flips ratio_i in the middle of a run of sixteen words. It keeps checking every receive word, every transmit bit, every take pulse and every bypass lane against the mode that was captured. Each mode is also swept through all sixteen transmit word values and a receive stream whose bit pattern differs between lanes, so that the node-pair mapping cannot be swapped without being seen.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  typedef enum logic {
    GBX_X2 = 1'b0,
    GBX_X4 = 1'b1
  } gbx_ratio_e;

  localparam int GBX_CNT_W = 2;
endpackage

// File: rtl/gbx_frame.sv
module gbx_frame
  import gbx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ratio_i,
  output gbx_ratio_e           mode_q,
  output logic                 armed_q,
  output logic                 take,
  output logic                 done,
  output logic                 vld_q
);
  logic [GBX_CNT_W-1:0] cnt_q, cnt_d;
  logic [GBX_CNT_W-1:0] last;
  gbx_ratio_e           mode_d;
  logic                 armed_d;
  logic                 vld_d;

  assign last = (mode_q == GBX_X4) ? GBX_CNT_W'(3) : GBX_CNT_W'(1);
  assign take = armed_q && (cnt_q == '0);
  assign done = armed_q && (cnt_q == last);

  always_comb begin
    mode_d  = mode_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    vld_d   = done;
    if (!armed_q) begin
      mode_d  = gbx_ratio_e'(ratio_i);
      armed_d = 1'b1;
    end else if (cnt_q == last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + GBX_CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= GBX_X2;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
    end
  end
endmodule

// File: rtl/gbx_deser.sv
module gbx_deser #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         done,
  input  logic         din,
  output logic [W-1:0] word_q
);
  logic [W-1:0] sr_q, sr_d, word_d, shifted;

  assign shifted = {sr_q[W-2:0], din};

  always_comb begin
    sr_d   = sr_q;
    word_d = word_q;
    if (en) sr_d = shifted;
    if (done) word_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      word_q <= '0;
    end else begin
      sr_q   <= sr_d;
      word_q <= word_d;
    end
  end
endmodule

// File: rtl/gbx_ser.sv
module gbx_ser #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] data,
  output logic         dout
);
  logic [W-1:0] sr_q, sr_d;

  assign dout = sr_q[W-1];

  always_comb begin
    sr_d = sr_q;
    if (load) sr_d = data;
    else if (en) sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/io_gearbox.sv
module io_gearbox
  import gbx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ratio_i,
  input  logic [LANES-1:0] pad_in,
  output logic [LANES-1:0] pad_out,
  output logic [LANES-1:0] rx_word,
  output logic             rx_vld,
  output logic [LANES-1:0] rx_byp,
  input  logic [LANES-1:0] tx_word,
  output logic             tx_take,
  input  logic [LANES-1:0] tx_byp
);
  localparam int WIDE   = LANES;
  localparam int NARROW = LANES / 2;
  localparam int LANE_B = LANES / 2;

  gbx_ratio_e       mode_q;
  logic             armed_q;
  logic             done;
  logic             take;
  logic [LANES-1:0] served;
  logic [LANES-1:0] ser_bit;
  logic [WIDE-1:0]  word_a;
  logic [NARROW-1:0] word_b;
  logic [WIDE-1:0]  load_a;
  logic             dout_a, dout_b;

  gbx_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .ratio_i (ratio_i),
    .mode_q  (mode_q),
    .armed_q (armed_q),
    .take    (take),
    .done    (done),
    .vld_q   (rx_vld)
  );

  assign tx_take = take;

  always_comb begin
    served = '0;
    served[0] = 1'b1;
    if (mode_q == GBX_X2) served[LANE_B] = 1'b1;
  end

  gbx_deser #(.W(WIDE)) u_rx_a (
    .clk(clk), .rst_n(rst_n), .en(armed_q), .done(done),
    .din(pad_in[0]), .word_q(word_a)
  );

  gbx_deser #(.W(NARROW)) u_rx_b (
    .clk(clk), .rst_n(rst_n), .en(armed_q), .done(done),
    .din(pad_in[LANE_B]), .word_q(word_b)
  );

  assign rx_word = (mode_q == GBX_X4) ? word_a : {word_a[NARROW-1:0], word_b};

  assign load_a = (mode_q == GBX_X4) ? tx_word
                                     : {tx_word[NARROW-1:0], {NARROW{1'b0}}};

  gbx_ser #(.W(WIDE)) u_tx_a (
    .clk(clk), .rst_n(rst_n), .en(armed_q), .load(take),
    .data(load_a), .dout(dout_a)
  );

  gbx_ser #(.W(NARROW)) u_tx_b (
    .clk(clk), .rst_n(rst_n), .en(armed_q), .load(take),
    .data(tx_word[WIDE-1:NARROW]), .dout(dout_b)
  );

  always_comb begin
    ser_bit = '0;
    ser_bit[0] = dout_a;
    ser_bit[LANE_B] = dout_b;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign pad_out[l] = served[l] ? ser_bit[l] : tx_byp[l];
    assign rx_byp[l]  = served[l] ? 1'b0 : pad_in[l];
  end
endmodule

// File: rtl/gbx_chk.sv
module gbx_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_q,
  input logic             armed_q,
  input logic [LANES-1:0] pad_in,
  input logic [LANES-1:0] pad_out,
  input logic [LANES-1:0] rx_word,
  input logic             rx_vld,
  input logic [LANES-1:0] tx_word,
  input logic             tx_take
);
  localparam int LB = LANES / 2;

  logic [2:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= tx_take ? 3'd0 : gap_q + 3'd1;
      if (tx_take) seen_q <= 1'b1;
    end
  end

  a_r1_x4_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && mode_q) |-> (rx_word[0] == $past(pad_in[0])));

  a_r2_x4_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_take) && mode_q) |-> (pad_out[0] == $past(tx_word[LANES-1])));

  a_r4_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> !rx_vld);

  a_r5_take_period: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && seen_q) |-> (gap_q == (mode_q ? 3'd3 : 3'd1)));

  a_r6_x2_first_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_take) && !mode_q) |->
      (pad_out[LB] == $past(tx_word[LANES-1]) && pad_out[0] == $past(tx_word[LB-1])));

  a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> $stable(mode_q));
endmodule

bind io_gearbox gbx_chk #(.LANES(LANES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_q  (mode_q),
  .armed_q (armed_q),
  .pad_in  (pad_in),
  .pad_out (pad_out),
  .rx_word (rx_word),
  .rx_vld  (rx_vld),
  .tx_word (tx_word),
  .tx_take (tx_take)
);

// File: tb/sim_io_gearbox.sv
`timescale 1ns/100ps
module sim_io_gearbox;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ratio_i;
  logic [3:0] pad_in, pad_out, rx_word, rx_byp, tx_word, tx_byp;
  logic       rx_vld, tx_take;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [3:0] bits_q [64];
  logic [3:0] words_q [16];

  io_gearbox u0 (
    .clk(clk), .rst_n(rst_n), .ratio_i(ratio_i), .pad_in(pad_in),
    .pad_out(pad_out), .rx_word(rx_word), .rx_vld(rx_vld), .rx_byp(rx_byp),
    .tx_word(tx_word), .tx_take(tx_take), .tx_byp(tx_byp)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic run_mode(bit x4, bit flip);
    int r = x4 ? 4 : 2;
    int n = 16 * r;
    logic [3:0] srv = x4 ? 4'b0001 : 4'b0101;
    rst_n = 1'b0; ratio_i = x4; pad_in = 4'hF; tx_word = 4'hF; tx_byp = 4'hA;
    repeat (2) @(negedge clk);
    #0.5;
    // R9 reset state
    chk("R9 rx_word", {4'h0, rx_word}, 8'h00);
    chk("R9 rx_vld", {7'h0, rx_vld}, 8'h00);
    chk("R9 tx_take", {7'h0, tx_take}, 8'h00);
    chk("R9 pad_out served", {4'h0, pad_out & srv}, 8'h00);
    for (int w = 0; w < 16; w++) words_q[w] = 4'((w * 5 + 3) & 15);
    for (int k = 0; k < n; k++) bits_q[k] = 4'((k * 7 + (k >> 2) * 3 + (k >> 4)) & 15);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);          // configuration cycle
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      int w = k / r;
      int j = k % r;
      logic [3:0] pw;
      if (flip && k == n / 2) ratio_i = ~x4;   // R8: late change ignored
      pad_in  = bits_q[k];
      tx_word = (j == 0) ? words_q[w] : 4'(~words_q[w]);
      tx_byp  = 4'((k * 3 + 9) & 15);
      #0.5;
      chk(flip ? "R5 R8 tx_take" : "R5 tx_take", {7'h0, tx_take}, {7'h0, (j == 0)});
      chk("R7 rx_byp", {4'h0, rx_byp}, {4'h0, pad_in & ~srv});
      chk("R7 pad_out bypass", {4'h0, pad_out & ~srv}, {4'h0, tx_byp & ~srv});
      @(posedge clk);
      @(negedge clk);
      pw = words_q[w];
      if (x4) begin
        chk("R2 pad_out[0]", {7'h0, pad_out[0]}, {7'h0, pw[3 - j]});
      end else begin
        chk("R6 pad_out[0]", {7'h0, pad_out[0]}, {7'h0, pw[1 - j]});
        chk("R6 pad_out[2]", {7'h0, pad_out[2]}, {7'h0, pw[3 - j]});
      end
      chk(flip ? "R4 R8 rx_vld" : "R4 rx_vld", {7'h0, rx_vld}, {7'h0, (j == r - 1)});
      if (j == r - 1) begin
        logic [3:0] e;
        int b = w * r;
        if (x4) begin
          e = {bits_q[b][0], bits_q[b+1][0], bits_q[b+2][0], bits_q[b+3][0]};
          chk("R1 rx_word", {4'h0, rx_word}, {4'h0, e});
        end else begin
          e = {bits_q[b][0], bits_q[b+1][0], bits_q[b][2], bits_q[b+1][2]};
          chk("R3 rx_word", {4'h0, rx_word}, {4'h0, e});
        end
      end
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    run_mode(1'b1, 1'b0);
    run_mode(1'b0, 1'b0);
    run_mode(1'b1, 1'b1);
    run_mode(1'b0, 1'b1);
    finish_run();
  end
endmodule